// File: doc/BRIEF.md
# Count/Compare Interval Timer

The block keeps a 32-bit up-counter that advances by one on every cycle that carries a count-enable tick. A 32-bit deadline register sits beside it. When an advance carries the counter onto the deadline value, the block raises its timer interrupt on request line 7 of an 8-line interrupt vector. The interrupt then stays high until software writes a new deadline. Writing the deadline is the only way to acknowledge the interrupt.

Software writes both registers through one shared write port. A select bit chooses the counter or the deadline. An external freeze input stops the counter. While the counter is frozen, no deadline can be reached. A 3-bit architecture-release input selects the flag behaviour. When it holds the value 1, the block also produces one-cycle strobes that set and clear a dedicated timer-flag bit, which is held outside the block. A match is detected only on an advance. So a deadline that equals the current count, or a count loaded equal to the deadline, fires only after the counter has gone all the way round.

Top module: `cc_timer_top`

## Requirements
- R1: After a synchronous reset the counter and the deadline are 0, every interrupt line is low and both flag strobes are low.
- R2: With the freeze input low, each cycle that has tick high and no counter write increments the counter by one, visible on the next cycle. A cycle without a tick leaves the counter unchanged.
- R3: While the freeze input is high, the counter holds its value and no interrupt is raised, even when a tick would have reached the deadline.
- R4: An advance from 0xFFFFFFFF gives 0.
- R5: When an advance makes the counter equal to the deadline, interrupt line 7 goes high on the next cycle. It stays high through later ticks until a deadline write.
- R6: A write with select = 1 loads the deadline on the next cycle and drives line 7 low on the next cycle. If a match occurs in the same cycle, the write wins and line 7 ends up low.
- R7: A write with select = 0 loads the counter on the next cycle and overrides any tick in that cycle. It leaves line 7 unchanged, and it does not cause a match even when the loaded value equals the deadline.
- R8: A deadline written equal to the current count does not fire at once. The next match needs the counter to advance onto that value again.
- R9: When the release input equals 1, a match produces a one-cycle set strobe in the same cycle that line 7 rises. A deadline write produces a one-cycle clear strobe. With any other release value both strobes stay low.
- R10: Interrupt lines other than line 7 are always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable tick |
| freeze | input | 1 | Count disable: holds the counter and blocks matches |
| rel_code | input | 3 | Architecture-release code; 1 enables the flag strobes |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 deadline |
| wr_data | input | 32 | Write data |
| irq_req | output | 8 | Interrupt request lines; timer drives line 7 |
| tflag_set | output | 1 | One-cycle pulse that sets the timer flag |
| tflag_clr | output | 1 | One-cycle pulse that clears the timer flag |
| count_q | output | 32 | Current counter value |
| deadline_q | output | 32 | Current deadline value |

## Verification
Some rules are checked on every cycle by the assertions:
- the frozen counter holds its value,
- register loads land on the next cycle,
- the counter wraps to zero,
- a deadline write always leaves the interrupt low,
- a counter write leaves it unchanged,
- the strobes never overlap and only appear in release mode 1,
- at most one interrupt line is high.

Other behaviour needs the bench's scenarios, because it depends on a chosen order of ticks and writes: the moment a match fires, the interrupt staying high across later ticks, a write beating a match in the same cycle, and a deadline equal to the count not firing.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

    localparam int unsigned CNT_W      = 32;
    localparam int unsigned IRQ_N      = 8;
    localparam int unsigned TIMER_LINE = 7;
    localparam int unsigned REL_W      = 3;
    localparam logic [REL_W-1:0] REL_FLAG_CODE = 3'd1;

    typedef enum logic {
        SEL_COUNT    = 1'b0,
        SEL_DEADLINE = 1'b1
    } wr_target_e;

    typedef struct packed {
        logic match;     // an advance landed on the deadline
        logic dl_wr;     // deadline write this cycle
        logic cnt_wr;    // counter write this cycle
    } tmr_evt_t;

    function automatic logic flag_mode(input logic [REL_W-1:0] rel);
        return rel == REL_FLAG_CODE;
    endfunction

endpackage

// File: rtl/cc_timer_counter.sv
module cc_timer_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         freeze,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] count,
    output logic         adv,
    output logic [W-1:0] next_val
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    always_comb begin
        adv      = tick && !freeze && !load;
        next_val = count + {{(W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_data;
        else if (adv)  count <= next_val;
    end

    assert_freeze_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (freeze && !load) |=> $stable(count));

    assert_count_load_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_data)));

    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !freeze && !load && count == ALL_ONES) |=> (count == '0));
endmodule

// File: rtl/cc_timer_deadline.sv
module cc_timer_deadline #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         adv,
    input  logic [W-1:0] next_val,
    output logic [W-1:0] deadline,
    output logic         match
);
    // Match only on an advance onto the deadline: equal-at-write waits a wrap.
    always_comb match = adv && (next_val == deadline);

    always_ff @(posedge clk) begin
        if (rst)     deadline <= '0;
        else if (wr) deadline <= wr_data;
    end

    assert_deadline_load_R6: assert property (@(posedge clk) disable iff (rst)
        wr |=> (deadline == $past(wr_data)));
endmodule

// File: rtl/cc_timer_irq.sv
module cc_timer_irq
    import cc_timer_pkg::*;
#(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned LINE    = 7,
    parameter int unsigned RW      = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  tmr_evt_t           evt,
    input  logic [RW-1:0]      rel,
    output logic [N_LINES-1:0] irq_o,
    output logic               set_o,
    output logic               clr_o
);
    logic pend;
    logic fm;

    always_comb fm = flag_mode(rel);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            set_o <= 1'b0;
            clr_o <= 1'b0;
        end else begin
            if (evt.dl_wr)      pend <= 1'b0;
            else if (evt.match) pend <= 1'b1;
            set_o <= fm && evt.match && !evt.dl_wr;
            clr_o <= fm && evt.dl_wr;
        end
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        if (i == LINE) begin : g_timer
            assign irq_o[i] = pend;
        end else begin : g_idle
            assign irq_o[i] = 1'b0;
        end
    end

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        evt.dl_wr |=> !pend);

    assert_match_raises_R5: assert property (@(posedge clk) disable iff (rst)
        (evt.match && !evt.dl_wr) |=> pend);

    assert_cnt_wr_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (evt.cnt_wr && !evt.dl_wr) |=> (pend == $past(pend)));

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(set_o && clr_o));

    assert_strobe_mode_R9: assert property (@(posedge clk) disable iff (rst)
        (set_o || clr_o) |-> $past(fm));

    assert_one_line_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_o));
endmodule

// File: rtl/cc_timer_top.sv
module cc_timer_top
    import cc_timer_pkg::*;
#(
    parameter int unsigned W       = CNT_W,
    parameter int unsigned N_LINES = IRQ_N,
    parameter int unsigned LINE    = TIMER_LINE,
    parameter int unsigned RW      = REL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               freeze,
    input  logic [RW-1:0]      rel_code,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [W-1:0]       wr_data,
    output logic [N_LINES-1:0] irq_req,
    output logic               tflag_set,
    output logic               tflag_clr,
    output logic [W-1:0]       count_q,
    output logic [W-1:0]       deadline_q
);
    tmr_evt_t   evt;
    logic       adv;
    logic       match;
    logic [W-1:0] next_val;

    always_comb begin
        evt.cnt_wr = wr_en && (wr_target_e'(wr_sel) == SEL_COUNT);
        evt.dl_wr  = wr_en && (wr_target_e'(wr_sel) == SEL_DEADLINE);
        evt.match  = match;
    end

    cc_timer_counter #(.W(W)) u_counter (
        .clk(clk), .rst(rst), .tick(tick), .freeze(freeze),
        .load(evt.cnt_wr), .load_data(wr_data),
        .count(count_q), .adv(adv), .next_val(next_val)
    );

    cc_timer_deadline #(.W(W)) u_deadline (
        .clk(clk), .rst(rst), .wr(evt.dl_wr), .wr_data(wr_data),
        .adv(adv), .next_val(next_val),
        .deadline(deadline_q), .match(match)
    );

    cc_timer_irq #(.N_LINES(N_LINES), .LINE(LINE), .RW(RW)) u_irq (
        .clk(clk), .rst(rst), .evt(evt), .rel(rel_code),
        .irq_o(irq_req), .set_o(tflag_set), .clr_o(tflag_clr)
    );
endmodule

// File: tb/cc_timer_top_tb.sv
module cc_timer_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        freeze = 1'b0;
    logic [2:0]  rel_code = 3'd0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  irq_req;
    logic        tflag_set, tflag_clr;
    logic [31:0] count_q, deadline_q;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cc_timer_top u_dut (
        .clk(clk), .rst(rst), .tick(tick), .freeze(freeze), .rel_code(rel_code),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_req(irq_req), .tflag_set(tflag_set), .tflag_clr(tflag_clr),
        .count_q(count_q), .deadline_q(deadline_q)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: inputs held from negedge to negedge
    task automatic cyc(input logic t, input logic we, input logic sel, input logic [31:0] d);
        tick = t; wr_en = we; wr_sel = sel; wr_data = d;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic load_count(input logic [31:0] v); cyc(1'b0, 1'b1, 1'b0, v); endtask
    task automatic load_dl(input logic [31:0] v);    cyc(1'b0, 1'b1, 1'b1, v); endtask

    task automatic t_reset;
        check("R1", "count", count_q, 32'd0);
        check("R1", "deadline", deadline_q, 32'd0);
        check("R1", "irq", {24'd0, irq_req}, 32'd0);
        check("R1", "strobes", {30'd0, tflag_set, tflag_clr}, 32'd0);
    endtask

    task automatic t_count;
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0, '0);
        check("R2", "five ticks", count_q, 32'd5);
        cyc(1'b0, 1'b0, 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b0, '0);
        check("R2", "idle holds", count_q, 32'd5);
        cyc(1'b1, 1'b0, 1'b0, '0);
        check("R2", "sparse tick", count_q, 32'd6);
    endtask

    task automatic t_freeze;
        load_dl(32'd40);
        load_count(32'd39);
        freeze = 1'b1;
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, '0);
        check("R3", "frozen count", count_q, 32'd39);
        check("R3", "no irq frozen", {31'd0, irq_req[7]}, 32'd0);
        freeze = 1'b0;
        load_dl(32'd1000);
    endtask

    task automatic t_wrap;
        load_count(32'hFFFF_FFFF);
        cyc(1'b1, 1'b0, 1'b0, '0);
        check("R4", "wrap", count_q, 32'd0);
    endtask

    task automatic t_match;
        rel_code = 3'd0;
        load_dl(32'd100);
        load_count(32'd98);
        cyc(1'b1, 1'b0, 1'b0, '0);
        check("R5", "before match", {31'd0, irq_req[7]}, 32'd0);
        cyc(1'b1, 1'b0, 1'b0, '0);
        check("R5", "match raises", {31'd0, irq_req[7]}, 32'd1);
        check("R9", "no set strobe rel0", {31'd0, tflag_set}, 32'd0);
        cyc(1'b1, 1'b0, 1'b0, '0);
        cyc(1'b1, 1'b0, 1'b0, '0);
        check("R5", "irq held", {31'd0, irq_req[7]}, 32'd1);
        check("R10", "other lines", {24'd0, irq_req & 8'h7F}, 32'd0);
        load_count(32'd5);
        check("R7", "count write keeps irq high", {31'd0, irq_req[7]}, 32'd1);
        check("R7", "count loaded", count_q, 32'd5);
        load_dl(32'd777);
        check("R6", "ack clears", {31'd0, irq_req[7]}, 32'd0);
        check("R6", "deadline loaded", deadline_q, 32'd777);
        check("R9", "no clr strobe rel0", {31'd0, tflag_clr}, 32'd0);
    endtask

    task automatic t_same_cycle;
        load_dl(32'd200);
        load_count(32'd199);
        cyc(1'b1, 1'b1, 1'b1, 32'd500);   // match and deadline write together
        check("R6", "write beats match", {31'd0, irq_req[7]}, 32'd0);
        check("R6", "count still advanced", count_q, 32'd200);
        check("R6", "new deadline", deadline_q, 32'd500);
    endtask

    task automatic t_count_write;
        load_count(32'd499);
        cyc(1'b1, 1'b1, 1'b0, 32'd10);    // count write overrides tick
        check("R7", "write overrides tick", count_q, 32'd10);
        load_count(32'd500);              // equal to deadline
        check("R7", "load equal no match", {31'd0, irq_req[7]}, 32'd0);
        cyc(1'b1, 1'b0, 1'b0, '0);
        check("R7", "past deadline no irq", {31'd0, irq_req[7]}, 32'd0);
    endtask

    task automatic t_equal;
        load_count(32'd300);
        load_dl(32'd300);
        check("R8", "equal no immediate", {31'd0, irq_req[7]}, 32'd0);
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, '0);
        check("R8", "still quiet", {31'd0, irq_req[7]}, 32'd0);
        load_count(32'd299);
        cyc(1'b1, 1'b0, 1'b0, '0);
        check("R8", "fires on return", {31'd0, irq_req[7]}, 32'd1);
        load_dl(32'd0);
    endtask

    task automatic t_flag;
        rel_code = 3'd1;
        load_dl(32'd50);
        cyc(1'b0, 1'b0, 1'b0, '0);
        load_count(32'd49);
        cyc(1'b1, 1'b0, 1'b0, '0);
        check("R9", "set pulse", {31'd0, tflag_set}, 32'd1);
        check("R9", "irq with set", {31'd0, irq_req[7]}, 32'd1);
        cyc(1'b0, 1'b0, 1'b0, '0);
        check("R9", "set one cycle", {31'd0, tflag_set}, 32'd0);
        load_dl(32'd60);
        check("R9", "clr pulse", {31'd0, tflag_clr}, 32'd1);
        cyc(1'b0, 1'b0, 1'b0, '0);
        check("R9", "clr one cycle", {31'd0, tflag_clr}, 32'd0);
        rel_code = 3'd2;
        load_count(32'd59);
        cyc(1'b1, 1'b0, 1'b0, '0);
        check("R9", "rel2 no set", {31'd0, tflag_set}, 32'd0);
        check("R5", "rel2 irq", {31'd0, irq_req[7]}, 32'd1);
        load_dl(32'd70);
        check("R9", "rel2 no clr", {31'd0, tflag_clr}, 32'd0);
        rel_code = 3'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count();
        t_freeze();
        t_wrap();
        t_match();
        t_same_cycle();
        t_count_write();
        t_equal();
        t_flag();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule